// File: doc/BRIEF.md
# Segmented Linear Address Generator

This block turns the parts of a memory operand into the address that goes to translation. It takes a base register value, an index register value, a two-bit scale code, a signed displacement and a segment code. It adds them to form the offset (effective address). It then adds the base of the chosen segment to get the linear address. A mode input selects 64-bit long mode or 32-bit legacy protected mode.

In long mode the ordinary code, data and stack segments count as flat with base zero. The two thread-local segments keep the bases software gave them. In legacy mode every segment applies its programmed base and all arithmetic wraps at 32 bits.

The block does no limit or privilege checks and loads no descriptors. Segment bases arrive as plain inputs. The result is registered, so it appears one cycle after the operand is presented.

Top module: `seg_linear_agu`

## Requirements
- R1: The offset equals base + (index scaled) + sign-extended displacement. In long mode this sum is taken modulo 2^64.
- R2: Scale code 0, 1, 2 and 3 multiplies the index by 1, 2, 4 and 8.
- R3: The 32-bit displacement is sign-extended from bit 31 to the address width before it is added, so a displacement with bit 31 set lowers the offset.
- R4: The linear address equals the selected segment's effective base plus the offset.
- R5: In long mode, segment codes 0 (ES), 1 (CS), 2 (SS) and 3 (DS) use base zero whatever their base input holds, so the linear address equals the offset.
- R6: In long mode, segment codes 4 (FS) and 5 (GS) apply the full 64-bit programmed base.
- R7: In legacy mode (long_mode = 0), every segment applies the low 32 bits of its programmed base. The offset and the linear address are both taken modulo 2^32, and their bits 63:32 are zero.
- R8: Segment codes 6 and 7 select base zero in both modes.
- R9: out_valid equals in_valid one cycle later. A cycle with in_valid = 0 leaves eff_addr and lin_addr unchanged.
- R10: After synchronous reset, out_valid, eff_addr and lin_addr are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand inputs are valid this cycle |
| base_val | input | ADDR_W | Base register value |
| index_val | input | ADDR_W | Index register value |
| scale_code | input | 2 | Index multiplier code (1, 2, 4, 8) |
| disp | input | DISP_W | Signed displacement |
| seg_sel | input | 3 | Segment code: 0 ES, 1 CS, 2 SS, 3 DS, 4 FS, 5 GS |
| seg_bases | input | 6*ADDR_W | Segment bases; segment k occupies bits k*ADDR_W upward |
| long_mode | input | 1 | 1 = 64-bit long mode, 0 = legacy 32-bit mode |
| out_valid | output | 1 | Registered result valid |
| eff_addr | output | ADDR_W | Registered offset (effective address) |
| lin_addr | output | ADDR_W | Registered linear address |

## Verification
The bench puts large nonzero bases in the flat segments during long mode. A design that failed to force those bases to zero would add them to the address. The thread-local segments get bases above 2^32, which exposes a design that truncated or zeroed them. Legacy operands are chosen so the sums carry past bit 31, and segment bases have stray upper bits; a missing 32-bit wrap or base mask would leave nonzero high bits. Negative displacements, each scale code, the unused segment codes and idle cycles between operands catch a zero-extended displacement, a wrong shift, garbage bases and outputs that change without a valid operand.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int unsigned SEG_CODE_W = 3;
  localparam int unsigned NUM_SEGS   = 6;

  typedef enum logic [SEG_CODE_W-1:0] {
    SEG_ES = 3'd0,
    SEG_CS = 3'd1,
    SEG_SS = 3'd2,
    SEG_DS = 3'd3,
    SEG_FS = 3'd4,
    SEG_GS = 3'd5
  } seg_code_e;

  // Segments whose base survives in long mode (thread-local storage)
  function automatic logic keeps_base_in_long(input int unsigned idx);
    return (idx == int'(SEG_FS)) || (idx == int'(SEG_GS));
  endfunction
endpackage

// File: rtl/agu_offset.sv
module agu_offset #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned LEG_W  = 32,
  parameter int unsigned DISP_W = 32
) (
  input  logic [ADDR_W-1:0] base_val,
  input  logic [ADDR_W-1:0] index_val,
  input  logic [1:0]        scale_code,
  input  logic [DISP_W-1:0] disp,
  input  logic              long_mode,
  output logic [ADDR_W-1:0] offset
);
  localparam int unsigned EXT_W = ADDR_W - DISP_W;
  localparam int unsigned HI_W  = ADDR_W - LEG_W;

  logic [ADDR_W-1:0] scaled_idx;
  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] raw_sum;

  always_comb begin
    scaled_idx = index_val << scale_code;
    disp_ext   = {{EXT_W{disp[DISP_W-1]}}, disp};
    raw_sum    = base_val + scaled_idx + disp_ext;
    if (long_mode) offset = raw_sum;
    else           offset = {{HI_W{1'b0}}, raw_sum[LEG_W-1:0]};
  end
endmodule

// File: rtl/agu_segbase.sv
module agu_segbase
  import agu_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned LEG_W  = 32
) (
  input  logic [NUM_SEGS*ADDR_W-1:0] seg_bases,
  input  logic [SEG_CODE_W-1:0]      seg_sel,
  input  logic                       long_mode,
  output logic [ADDR_W-1:0]          sel_base
);
  localparam int unsigned HI_W = ADDR_W - LEG_W;

  logic [ADDR_W-1:0] eff_base [NUM_SEGS];

  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_seg
    logic [ADDR_W-1:0] prog;
    assign prog = seg_bases[g*ADDR_W +: ADDR_W];
    if (keeps_base_in_long(g)) begin : g_tls
      assign eff_base[g] = long_mode ? prog : {{HI_W{1'b0}}, prog[LEG_W-1:0]};
    end else begin : g_flat
      assign eff_base[g] = long_mode ? '0 : {{HI_W{1'b0}}, prog[LEG_W-1:0]};
    end
  end

  always_comb begin
    sel_base = '0;
    for (int k = 0; k < NUM_SEGS; k++) begin
      if (seg_sel == SEG_CODE_W'(k)) sel_base = eff_base[k];
    end
  end
endmodule

// File: rtl/seg_linear_agu.sv
module seg_linear_agu
  import agu_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned LEG_W  = 32,
  parameter int unsigned DISP_W = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [ADDR_W-1:0]          base_val,
  input  logic [ADDR_W-1:0]          index_val,
  input  logic [1:0]                 scale_code,
  input  logic [DISP_W-1:0]          disp,
  input  logic [SEG_CODE_W-1:0]      seg_sel,
  input  logic [NUM_SEGS*ADDR_W-1:0] seg_bases,
  input  logic                       long_mode,
  output logic                       out_valid,
  output logic [ADDR_W-1:0]          eff_addr,
  output logic [ADDR_W-1:0]          lin_addr
);
  localparam int unsigned HI_W = ADDR_W - LEG_W;

  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] sel_base;
  logic [ADDR_W-1:0] lin_sum;
  logic [ADDR_W-1:0] lin_next;

  agu_offset #(.ADDR_W(ADDR_W), .LEG_W(LEG_W), .DISP_W(DISP_W)) u_off (
    .base_val  (base_val),
    .index_val (index_val),
    .scale_code(scale_code),
    .disp      (disp),
    .long_mode (long_mode),
    .offset    (offset)
  );

  agu_segbase #(.ADDR_W(ADDR_W), .LEG_W(LEG_W)) u_seg (
    .seg_bases(seg_bases),
    .seg_sel  (seg_sel),
    .long_mode(long_mode),
    .sel_base (sel_base)
  );

  always_comb begin
    lin_sum  = sel_base + offset;
    lin_next = long_mode ? lin_sum : {{HI_W{1'b0}}, lin_sum[LEG_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      eff_addr  <= '0;
      lin_addr  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        eff_addr <= offset;
        lin_addr <= lin_next;
      end
    end
  end
endmodule

// File: rtl/agu_checker.sv
module agu_checker
  import agu_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned LEG_W  = 32
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic [SEG_CODE_W-1:0] seg_sel,
  input logic                  long_mode,
  input logic                  out_valid,
  input logic [ADDR_W-1:0]     eff_addr,
  input logic [ADDR_W-1:0]     lin_addr
);
  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (!out_valid && eff_addr == '0 && lin_addr == '0));

  p_valid_follow_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_valid_drop_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(eff_addr) && $stable(lin_addr)));

  p_legacy_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !long_mode) |=>
      (eff_addr[ADDR_W-1:LEG_W] == '0 && lin_addr[ADDR_W-1:LEG_W] == '0));

  p_flat_base_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && long_mode && seg_sel <= SEG_CODE_W'(SEG_DS)) |=> (lin_addr == eff_addr));

  p_unused_seg_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && seg_sel >= SEG_CODE_W'(NUM_SEGS)) |=> (lin_addr == eff_addr));
endmodule

bind seg_linear_agu agu_checker #(.ADDR_W(ADDR_W), .LEG_W(LEG_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .seg_sel  (seg_sel),
  .long_mode(long_mode),
  .out_valid(out_valid),
  .eff_addr (eff_addr),
  .lin_addr (lin_addr)
);

// File: tb/tb_seg_linear_agu.sv
module tb_seg_linear_agu;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [63:0]  base_val, index_val;
  logic [1:0]   scale_code;
  logic [31:0]  disp;
  logic [2:0]   seg_sel;
  logic [383:0] seg_bases;
  logic         long_mode;
  logic         out_valid;
  logic [63:0]  eff_addr, lin_addr;

  logic [63:0] bases [6];
  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic        m_valid;
  logic [63:0] m_eff, m_lin;

  seg_linear_agu dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .base_val(base_val),
    .index_val(index_val), .scale_code(scale_code), .disp(disp),
    .seg_sel(seg_sel), .seg_bases(seg_bases), .long_mode(long_mode),
    .out_valid(out_valid), .eff_addr(eff_addr), .lin_addr(lin_addr)
  );

  always #10 clk = ~clk;

  function automatic logic [63:0] ref_off(logic [63:0] b, logic [63:0] i,
                                          logic [1:0] sc, logic [31:0] d, logic lm);
    longint signed dsx = longint'($signed(d));
    logic [63:0] t = b + i * (64'd1 << sc) + 64'(dsx);
    return lm ? t : (t & 64'hFFFF_FFFF);
  endfunction

  function automatic logic [63:0] ref_base(logic [2:0] s, logic lm);
    if (s > 3'd5) return 64'd0;
    if (lm) return (s == 3'd4 || s == 3'd5) ? bases[s] : 64'd0;
    return bases[s] & 64'hFFFF_FFFF;
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One clock: apply inputs, advance model, compare at following negedge
  task automatic step(string tag, logic v, logic [63:0] b, logic [63:0] i,
                      logic [1:0] sc, logic [31:0] d, logic [2:0] s, logic lm);
    logic [63:0] o;
    in_valid = v; base_val = b; index_val = i; scale_code = sc;
    disp = d; seg_sel = s; long_mode = lm;
    for (int k = 0; k < 6; k++) seg_bases[k*64 +: 64] = bases[k];
    o = ref_off(b, i, sc, d, lm);
    m_valid = v;
    if (v) begin
      m_eff = o;
      m_lin = (ref_base(s, lm) + o) & (lm ? 64'hFFFF_FFFF_FFFF_FFFF : 64'hFFFF_FFFF);
    end
    @(negedge clk);
    chk(tag, "out_valid", {63'd0, out_valid}, {63'd0, m_valid});
    chk(tag, "eff_addr", eff_addr, m_eff);
    chk(tag, "lin_addr", lin_addr, m_lin);
  endtask

  initial begin
    bases[0] = 64'h0000_0000_1111_0000;
    bases[1] = 64'h0000_0000_2222_0000;
    bases[2] = 64'hABCD_0000_3333_0000;
    bases[3] = 64'h0000_0001_4444_0000;
    bases[4] = 64'h0000_7FFF_0000_1000;
    bases[5] = 64'hFFFF_8000_0000_2000;
    rst = 1'b1; in_valid = 0; base_val = 0; index_val = 0; scale_code = 0;
    disp = 0; seg_sel = 0; long_mode = 0;
    for (int k = 0; k < 6; k++) seg_bases[k*64 +: 64] = bases[k];
    repeat (3) @(negedge clk);
    checks++; if (out_valid !== 1'b0) begin failures++; $display("FAIL R10 out_valid actual=%b expected=0", out_valid); end
    checks++; if (eff_addr !== 64'd0) begin failures++; $display("FAIL R10 eff_addr actual=%h expected=0", eff_addr); end
    checks++; if (lin_addr !== 64'd0) begin failures++; $display("FAIL R10 lin_addr actual=%h expected=0", lin_addr); end
    m_valid = 0; m_eff = 0; m_lin = 0;
    rst = 1'b0;

    // R1 long-mode 64-bit carry; R5 DS flat
    step("R1", 1, 64'h0000_0000_FFFF_FFF0, 64'h40, 2'd0, 32'h10, 3'd3, 1);
    step("R5", 1, 64'h1000, 64'h8, 2'd2, 32'h4, 3'd0, 1);
    step("R5", 1, 64'h2000, 64'h8, 2'd1, 32'h0, 3'd1, 1);
    step("R5", 1, 64'h3000, 64'h0, 2'd0, 32'h0, 3'd2, 1);
    // R2 every scale code
    for (int sc = 0; sc < 4; sc++)
      step("R2", 1, 64'h100, 64'h3, 2'(sc), 32'h0, 3'd3, 1);
    // R3 negative displacement, both modes
    step("R3", 1, 64'h1_0000_0000, 64'h0, 2'd0, 32'hFFFF_FFF0, 3'd3, 1);
    step("R3", 1, 64'h100, 64'h0, 2'd0, 32'h8000_0000, 3'd0, 0);
    // R6 thread-local segments in long mode; R4 base+offset
    step("R6", 1, 64'h40, 64'h2, 2'd3, 32'h8, 3'd4, 1);
    step("R6", 1, 64'h40, 64'h2, 2'd3, 32'h8, 3'd5, 1);
    step("R4", 1, 64'h10, 64'h1, 2'd1, 32'h0, 3'd5, 1);
    // R7 legacy: bases applied, wrap at 2^32, upper base bits dropped
    step("R7", 1, 64'hFFFF_FFF0, 64'h0, 2'd0, 32'h20, 3'd3, 0);
    step("R7", 1, 64'h1234, 64'h10, 2'd3, 32'h0, 3'd2, 0);
    step("R7", 1, 64'h5555_0000_0000_0100, 64'h1, 2'd0, 32'h0, 3'd4, 0);
    step("R7", 1, 64'hF000_0000, 64'h0, 2'd0, 32'h0, 3'd5, 0);
    // R8 unused segment codes
    step("R8", 1, 64'h777, 64'h1, 2'd0, 32'h0, 3'd6, 1);
    step("R8", 1, 64'h777, 64'h1, 2'd0, 32'h0, 3'd7, 0);
    // R9 idle cycles hold outputs, then valid again
    step("R9", 0, 64'hDEAD, 64'hBEEF, 2'd3, 32'h1, 3'd4, 1);
    step("R9", 0, 64'h1, 64'h1, 2'd0, 32'h1, 3'd0, 0);
    step("R9", 1, 64'h9, 64'h1, 2'd0, 32'h0, 3'd0, 0);
    step("R9", 0, 64'h0, 64'h0, 2'd0, 32'h0, 3'd0, 0);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule